// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices. A parameter sets how many slices are chained into one wider count. All slices share the clock, an active-low synchronous clear, an active-low synchronous parallel load and a parallel count enable. A second enable, the trickle enable, enters the lowest slice. It is passed upward as each slice's carry. Every slice flop updates on the same rising edge, so the wide count moves as one word and never shows intermediate values.

Each slice drives its own carry. A slice carry is high while that slice holds all ones and the trickle reaching the slice is high. The top-level carry is high while the whole count is all ones and the trickle enable is high. Both carries are combinational, so an outside slice or a second counter can be cascaded on without extra gating. A decoded count value can be fed back into the clear input to shorten the count cycle to any modulus.

Top module: `casc_bin_counter`

## Requirements
- R1: When `clear_n_i` is 0 at a rising edge, `count_o` becomes all zeros after that edge. This holds whatever the levels of `load_n_i` and both enables are, so clear wins over load.
- R2: When `clear_n_i` is 1 and `load_n_i` is 0 at a rising edge, `count_o` takes `preset_i` after that edge, whatever the enable levels are.
- R3: With clear and load both high and both `cnt_en_par_i` and `cnt_en_trk_i` high at an edge, `count_o` increases by one modulo 2^(4*NUM_SLICES). All-ones wraps to zero in a single edge.
- R4: With clear and load both high and either enable low at an edge, `count_o` keeps its value.
- R5: Bit k of `slice_carry_o` is high exactly when count bits [4k+3:4k] are all ones and the trickle into slice k is high. Slice 0 takes `cnt_en_trk_i` as its trickle, and slice k takes `slice_carry_o[k-1]`. A slice therefore advances only in the edge where every lower slice holds all ones.
- R6: `carry_o` is high exactly when `count_o` is all ones and `cnt_en_trk_i` is high. It follows `cnt_en_trk_i` with no clock edge.
- R7: Changes on clear, load, enables or preset between rising edges leave `count_o` unchanged until the next rising edge.
- R8: Driving `clear_n_i` low while `count_o` equals a value N gives a cycle 0, 1, ..., N, 0 of length N+1, with the return to zero on the edge after N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every state change is on its rising edge |
| clear_n_i | input | 1 | Synchronous clear, active low, highest priority |
| load_n_i | input | 1 | Synchronous parallel load, active low |
| cnt_en_par_i | input | 1 | Parallel count enable, shared by all slices, gates counting only |
| cnt_en_trk_i | input | 1 | Trickle count enable into slice 0, gates counting and carries |
| preset_i | input | 4*NUM_SLICES | Parallel load data |
| count_o | output | 4*NUM_SLICES | Current count |
| slice_carry_o | output | NUM_SLICES | Per-slice carry, bit k from slice k |
| carry_o | output | 1 | Carry for the whole chain |

## Verification
The main function is tried in several ways. A clear-preset-count run starts from 12 and crosses the slice boundary at 0x0F to 0x10, which tells a proper carry chain apart from slices that count on their own. Two hold patterns each drop one enable. They show that both enables gate counting, while only the trickle enable gates the carries. A full walk over all 2^8 values with a reference model covers the all-ones to zero wrap. Directed cases cover clear and load low together, mid-cycle input changes with no edge, and a trickle toggle that must move the carry without a clock. A decoded-count feedback into clear checks a modulus-10 cycle.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

   // Operation chosen for one clock edge, ordered by priority.
   typedef enum logic [1:0] {
      OP_RUN   = 2'd0,
      OP_LOAD  = 2'd1,
      OP_CLEAR = 2'd2
   } cnt_op_e;

   // Clear outranks load; otherwise the slice runs (count or hold).
   function automatic cnt_op_e pick_op(input logic clr_n, input logic ld_n);
      cnt_op_e op;
      if (!clr_n)     op = OP_CLEAR;
      else if (!ld_n) op = OP_LOAD;
      else            op = OP_RUN;
      return op;
   endfunction

endpackage

// File: rtl/casc_cnt_ctrl.sv
module casc_cnt_ctrl
   import casc_cnt_pkg::*;
(
   input  logic    clear_n_i,
   input  logic    load_n_i,
   output cnt_op_e op_o
);

   always_comb begin
      op_o = pick_op(clear_n_i, load_n_i);
   end

endmodule

// File: rtl/casc_cnt_slice.sv
module casc_cnt_slice
   import casc_cnt_pkg::*;
#(
   parameter int unsigned W = 4
)(
   input  logic         clk_i,
   input  cnt_op_e      op_i,
   input  logic         en_par_i,
   input  logic         en_trk_i,
   input  logic [W-1:0] preset_i,
   output logic [W-1:0] q_o,
   output logic         carry_o
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ALL_ZERO = '0;

   logic [W-1:0] q_q;
   logic [W-1:0] q_d;
   logic         step;

   assign step = en_par_i & en_trk_i;

   always_comb begin
      unique case (op_i)
         OP_CLEAR: q_d = ALL_ZERO;
         OP_LOAD:  q_d = preset_i;
         default:  q_d = step ? (q_q + 1'b1) : q_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      q_q <= q_d;
   end

   assign q_o     = q_q;
   assign carry_o = en_trk_i & (q_q == ALL_ONES);

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
   import casc_cnt_pkg::*;
#(
   parameter int unsigned SLICE_W         = 4,
   parameter int unsigned NUM_SLICES      = 2,
   parameter int unsigned LOOKAHEAD_CARRY = 1
)(
   input  logic                          clk_i,
   input  logic                          clear_n_i,
   input  logic                          load_n_i,
   input  logic                          cnt_en_par_i,
   input  logic                          cnt_en_trk_i,
   input  logic [SLICE_W*NUM_SLICES-1:0] preset_i,
   output logic [SLICE_W*NUM_SLICES-1:0] count_o,
   output logic [NUM_SLICES-1:0]         slice_carry_o,
   output logic                          carry_o
);

   localparam int unsigned TOTAL_W = SLICE_W * NUM_SLICES;

   // Elaboration-time parameter checks
   if (SLICE_W < 1) begin : g_bad_width
      $error("casc_bin_counter: SLICE_W must be at least 1");
   end
   if (NUM_SLICES < 1) begin : g_bad_slices
      $error("casc_bin_counter: NUM_SLICES must be at least 1");
   end
   if (LOOKAHEAD_CARRY > 1) begin : g_bad_variant
      $error("casc_bin_counter: LOOKAHEAD_CARRY must be 0 or 1");
   end

   cnt_op_e              op;
   logic [NUM_SLICES-1:0] trk_in;
   logic [NUM_SLICES-1:0] slice_full;

   casc_cnt_ctrl u_ctrl (
      .clear_n_i (clear_n_i),
      .load_n_i  (load_n_i),
      .op_o      (op)
   );

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      assign slice_full[k] = &count_o[k*SLICE_W +: SLICE_W];

      casc_cnt_slice #(.W(SLICE_W)) u_slice (
         .clk_i    (clk_i),
         .op_i     (op),
         .en_par_i (cnt_en_par_i),
         .en_trk_i (trk_in[k]),
         .preset_i (preset_i[k*SLICE_W +: SLICE_W]),
         .q_o      (count_o[k*SLICE_W +: SLICE_W]),
         .carry_o  (slice_carry_o[k])
      );
   end

   if (LOOKAHEAD_CARRY == 1) begin : g_lookahead
      // Each trickle input is one wide AND over all lower slices.
      for (genvar k = 0; k < NUM_SLICES; k++) begin : g_trk
         localparam logic [NUM_SLICES-1:0] LOWER = NUM_SLICES'((64'd1 << k) - 64'd1);
         assign trk_in[k] = cnt_en_trk_i & (&(slice_full | ~LOWER));
      end
      assign carry_o = cnt_en_trk_i & (&slice_full);
   end else begin : g_ripple
      // Each slice carry feeds the next slice's trickle input.
      assign trk_in[0] = cnt_en_trk_i;
      for (genvar k = 1; k < NUM_SLICES; k++) begin : g_trk
         assign trk_in[k] = slice_carry_o[k-1];
      end
      assign carry_o = slice_carry_o[NUM_SLICES-1];
   end

endmodule

// File: rtl/casc_cnt_chk.sv
module casc_cnt_chk #(
   parameter int unsigned SLICE_W    = 4,
   parameter int unsigned NUM_SLICES = 2
)(
   input logic                          clk_i,
   input logic                          clear_n_i,
   input logic                          load_n_i,
   input logic                          cnt_en_par_i,
   input logic                          cnt_en_trk_i,
   input logic [SLICE_W*NUM_SLICES-1:0] preset_i,
   input logic [SLICE_W*NUM_SLICES-1:0] count_o,
   input logic [NUM_SLICES-1:0]         slice_carry_o,
   input logic                          carry_o
);

   localparam int unsigned TOTAL_W = SLICE_W * NUM_SLICES;

   // Becomes 1 after the first clear; the count is unknown before it.
   logic armed = 1'b0;
   always_ff @(posedge clk_i) begin
      armed <= armed | ~clear_n_i;
   end

   // R1
   clear_zero_chk: assert property (@(posedge clk_i) disable iff (!armed)
      !clear_n_i |=> (count_o == '0));

   // R2
   load_take_chk: assert property (@(posedge clk_i) disable iff (!armed)
      (clear_n_i && !load_n_i) |=> (count_o == $past(preset_i)));

   // R3
   count_step_chk: assert property (@(posedge clk_i) disable iff (!armed)
      (clear_n_i && load_n_i && cnt_en_par_i && cnt_en_trk_i)
      |=> (count_o == TOTAL_W'($past(count_o) + 1'b1)));

   // R4
   count_hold_chk: assert property (@(posedge clk_i) disable iff (!armed)
      (clear_n_i && load_n_i && !(cnt_en_par_i && cnt_en_trk_i))
      |=> $stable(count_o));

   // R5
   slice0_carry_chk: assert property (@(posedge clk_i) disable iff (!armed)
      slice_carry_o[0] == (cnt_en_trk_i && (&count_o[SLICE_W-1:0])));

   for (genvar k = 1; k < NUM_SLICES; k++) begin : g_chain
      // R5
      slice_chain_chk: assert property (@(posedge clk_i) disable iff (!armed)
         slice_carry_o[k] == (slice_carry_o[k-1] && (&count_o[k*SLICE_W +: SLICE_W])));
   end

   // R6
   top_carry_chk: assert property (@(posedge clk_i) disable iff (!armed)
      carry_o == (cnt_en_trk_i && (&count_o)));

endmodule

bind casc_bin_counter casc_cnt_chk #(
   .SLICE_W    (SLICE_W),
   .NUM_SLICES (NUM_SLICES)
) u_chk (
   .clk_i         (clk_i),
   .clear_n_i     (clear_n_i),
   .load_n_i      (load_n_i),
   .cnt_en_par_i  (cnt_en_par_i),
   .cnt_en_trk_i  (cnt_en_trk_i),
   .preset_i      (preset_i),
   .count_o       (count_o),
   .slice_carry_o (slice_carry_o),
   .carry_o       (carry_o)
);

// File: tb/casc_bin_counter_bench.sv
module casc_bin_counter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;
   localparam int W  = 4 * NS;
   localparam int NROWS = 16;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         ld_n = 1'b1;
   logic         en_p = 1'b0;
   logic         en_t = 1'b0;
   logic [W-1:0] pre = '0;
   logic         fb_mode = 1'b0;
   logic         clr_drv;
   logic [W-1:0] cnt;
   logic [NS-1:0] slc;
   logic         cry;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Decoded count of 9 drives clear in feedback mode (R8).
   assign clr_drv = fb_mode ? (cnt != 8'd9) : clr_n;

   casc_bin_counter #(.NUM_SLICES(NS)) u_casc_bin_counter (
      .clk_i         (clk),
      .clear_n_i     (clr_drv),
      .load_n_i      (ld_n),
      .cnt_en_par_i  (en_p),
      .cnt_en_trk_i  (en_t),
      .preset_i      (pre),
      .count_o       (cnt),
      .slice_carry_o (slc),
      .carry_o       (cry)
   );

   // Row: {clr_n, ld_n, par, trk, preset[7:0], exp_count[7:0], exp_slc[1:0], exp_carry}
   localparam logic [22:0] VEC [NROWS] = '{
      {4'b0111, 8'h00, 8'h00, 2'b00, 1'b0},  // clear (reset state)
      {4'b1000, 8'h0C, 8'h0C, 2'b00, 1'b0},  // load 12
      {4'b1111, 8'h00, 8'h0D, 2'b00, 1'b0},
      {4'b1111, 8'h00, 8'h0E, 2'b00, 1'b0},
      {4'b1111, 8'h00, 8'h0F, 2'b01, 1'b0},
      {4'b1111, 8'h00, 8'h10, 2'b00, 1'b0},  // slice boundary
      {4'b1111, 8'h00, 8'h11, 2'b00, 1'b0},
      {4'b1111, 8'h00, 8'h12, 2'b00, 1'b0},
      {4'b1101, 8'h00, 8'h12, 2'b00, 1'b0},  // hold, par low
      {4'b1110, 8'h00, 8'h12, 2'b00, 1'b0},  // hold, trk low
      {4'b1011, 8'hFE, 8'hFE, 2'b00, 1'b0},  // load with enables high
      {4'b1111, 8'h00, 8'hFF, 2'b11, 1'b1},
      {4'b1111, 8'h00, 8'h00, 2'b00, 1'b0},  // full wrap
      {4'b1010, 8'hFF, 8'hFF, 2'b00, 1'b0},  // all ones, trk low
      {4'b0011, 8'h55, 8'h00, 2'b00, 1'b0},  // clear beats load
      {4'b1001, 8'h3F, 8'h3F, 2'b01, 1'b0}   // lower slice full only
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic string row_req(input logic [3:0] m);
      if (!m[3])               return "R1 table";
      if (!m[2])               return "R2 table";
      if (m[1] && m[0])        return "R3 table";
      return "R4 table";
   endfunction

   function automatic logic [NS-1:0] model_slc(input logic [W-1:0] c, input logic t);
      logic [NS-1:0] s;
      logic          run;
      run = t;
      for (int k = 0; k < NS; k++) begin
         run  = run & (c[k*4 +: 4] == 4'hF);
         s[k] = run;
      end
      return s;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] m;
      logic [W-1:0] held;

      // Table walk: R1, R2, R3, R4, R5, R6
      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         {clr_n, ld_n, en_p, en_t} = VEC[i][22:19];
         pre = VEC[i][18:11];
         @(posedge clk);
         #(CLK_PERIOD/4);
         chk($sformatf("%s row %0d count", row_req(VEC[i][22:19]), i), 32'(cnt), 32'(VEC[i][10:3]));
         chk($sformatf("R5 row %0d slice carry", i), 32'(slc), 32'(VEC[i][2:1]));
         chk($sformatf("R6 row %0d carry", i), 32'(cry), 32'(VEC[i][0]));
      end

      // R3 / R5 / R6: full walk against a reference model
      @(negedge clk);
      clr_n = 1'b0; ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr_n = 1'b1;
      m = '0;
      for (int i = 0; i < 260; i++) begin
         @(posedge clk);
         m = m + 1'b1;
         #(CLK_PERIOD/4);
         chk("R3 walk count", 32'(cnt), 32'(m));
         chk("R5 walk slice carry", 32'(slc), 32'(model_slc(m, 1'b1)));
         chk("R6 walk carry", 32'(cry), 32'(m == 8'hFF));
      end

      // R7: input changes between edges leave the count alone
      @(negedge clk);
      en_p = 1'b0;
      held = cnt;
      clr_n = 1'b0; #1;
      chk("R7 clear low mid-cycle", 32'(cnt), 32'(held));
      clr_n = 1'b1; ld_n = 1'b0; pre = 8'hA5; #1;
      chk("R7 load low mid-cycle", 32'(cnt), 32'(held));
      ld_n = 1'b1; en_p = 1'b1; #1;
      chk("R7 enables high mid-cycle", 32'(cnt), 32'(held));
      en_p = 1'b0;
      @(posedge clk); #(CLK_PERIOD/4);
      chk("R4 hold after mid-cycle changes", 32'(cnt), 32'(held));

      // R6: carry follows the trickle enable with no edge
      @(negedge clk);
      ld_n = 1'b0; pre = 8'hFF; en_p = 1'b0; en_t = 1'b1;
      @(posedge clk); #(CLK_PERIOD/4);
      ld_n = 1'b1;
      chk("R6 carry at all ones", 32'(cry), 32'd1);
      en_t = 1'b0; #1;
      chk("R6 carry drops with trickle", 32'(cry), 32'd0);
      chk("R5 slice carries drop with trickle", 32'(slc), 32'd0);
      en_t = 1'b1; #1;
      chk("R6 carry rises with trickle", 32'(cry), 32'd1);

      // R8: decoded 9 fed back to clear gives a 10-state cycle
      @(negedge clk);
      clr_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      clr_n = 1'b1; en_p = 1'b1; en_t = 1'b1; fb_mode = 1'b1;
      m = '0;
      for (int i = 0; i < 25; i++) begin
         @(posedge clk);
         m = (m == 8'd9) ? 8'd0 : m + 1'b1;
         #(CLK_PERIOD/4);
         chk("R8 short cycle", 32'(cnt), 32'(m));
      end
      @(negedge clk);
      fb_mode = 1'b0;

      finish_run();
   end

endmodule